// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits between the storage array's read path and the byte-wide output bus of a paged nonvolatile memory. While an internal programming cycle runs, it replaces the array data with a status byte. The host can detect the end of the write in two ways, and both work together. Bit 7 carries the complement of bit 7 of the byte most recently written. Bit 6 flips on every new read access. All other bits repeat the byte most recently written.

When programming finishes, the block returns true array data on all eight bits and the bit 6 flipping stops. A new read access begins when the combined read strobe becomes active. The host can start one by pulsing output enable, chip enable, or both. The output stage is registered, so each read result appears one clock after the strobes and inputs that produced it. The analog timing of the output drivers is not modelled.

Top module: `poll_status_top`

## Requirements
- R1: The output enable `busOe` is 1 one clock after a cycle in which `ceN`=0, `oeN`=0 and `weN`=1; otherwise it is 0 and `busOut` is 0x00.
- R2: During a read taken while `busy`=1, `busOut[7]` is the inverse of `lastData[7]` as it stood in that cycle.
- R3: While `busy`=1, each new read access inverts bit 6 relative to the previous new access. The bit 6 state is 0 after reset, so the first busy access after reset returns 1.
- R4: A new read access is the first cycle of read activity after a cycle without it. It can be produced by raising and lowering either `oeN` or `ceN`.
- R5: While a read is held active across several clocks with `busy`=1, `busOut[6]` does not change.
- R6: While `busy`=0, a read returns `arrayData` unchanged on all eight bits, and reads do not advance the bit 6 state.
- R7: During a read taken while `busy`=1, `busOut[5:0]` equals `lastData[5:0]`.
- R8: The bit 6 state is kept across the end of one programming cycle and the start of the next. Polling may begin at any point in a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| busy | input | 1 | Internal programming cycle in progress |
| lastData | input | 8 | Byte most recently written |
| arrayData | input | 8 | Data read from the storage array |
| busOut | output | 8 | Read data toward the bus |
| busOe | output | 1 | Bus drive enable |

## Verification
A corrupted bit 6 state register shows up as an out-of-step bit 6 on the very next busy read. Because every later new access compares against the host's running expectation, the error stays visible from then on. A wrong edge detector reveals itself in one of two ways:
- Bit 6 moves while a read is held (R5).
- Bit 6 stays put across an output-enable or chip-enable pulse (R3, R4).

Either appears one clock after the offending access. A bad status/array select corrupts all eight bits on the first read after `busy` changes.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;
  typedef struct packed {
    logic readAct;    // read strobes active this cycle
    logic statusSel;  // return status byte instead of array data
    logic togBit;     // bit 6 value for this access
  } pollCtl_t;
endpackage

// File: rtl/poll_status_ctrl.sv
module poll_status_ctrl
  import poll_status_pkg::*;
#(
  parameter logic TogInit = 1'b0
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceN,
  input  logic     oeN,
  input  logic     weN,
  input  logic     busy,
  output pollCtl_t ctl
);
  logic readAct;
  logic prevAct;
  logic readStart;
  logic togQ;
  logic togNext;

  assign readAct   = ~ceN & ~oeN & weN;
  assign readStart = readAct & ~prevAct;
  assign togNext   = togQ ^ (busy & readStart);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAct <= 1'b0;
      togQ    <= TogInit;
    end else begin
      prevAct <= readAct;
      togQ    <= togNext;
    end
  end

  always_comb begin
    ctl.readAct   = readAct;
    ctl.statusSel = busy;
    ctl.togBit    = togNext;
  end
endmodule

// File: rtl/poll_status_dpath.sv
module poll_status_dpath
  import poll_status_pkg::*;
#(
  parameter int DataW     = 8,
  parameter int PollBit   = 7,
  parameter int ToggleBit = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  pollCtl_t         ctl,
  input  logic [DataW-1:0] lastData,
  input  logic [DataW-1:0] arrayData,
  output logic [DataW-1:0] busOut,
  output logic             busOe
);
  logic [DataW-1:0] statusByte;
  logic [DataW-1:0] outQ;
  logic             oeQ;

  always_comb begin
    statusByte            = lastData;
    statusByte[PollBit]   = ~lastData[PollBit];
    statusByte[ToggleBit] = ctl.togBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ <= '0;
      oeQ  <= 1'b0;
    end else begin
      oeQ  <= ctl.readAct;
      if (!ctl.readAct)
        outQ <= '0;
      else if (ctl.statusSel)
        outQ <= statusByte;
      else
        outQ <= arrayData;
    end
  end

  assign busOut = outQ;
  assign busOe  = oeQ;
endmodule

// File: rtl/poll_status_top.sv
module poll_status_top
  import poll_status_pkg::*;
#(
  parameter int   DataW     = 8,
  parameter int   PollBit   = 7,
  parameter int   ToggleBit = 6,
  parameter logic TogInit   = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             oeN,
  input  logic             weN,
  input  logic             busy,
  input  logic [DataW-1:0] lastData,
  input  logic [DataW-1:0] arrayData,
  output logic [DataW-1:0] busOut,
  output logic             busOe
);
  pollCtl_t ctl;

  poll_status_ctrl #(.TogInit(TogInit)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .busy(busy), .ctl(ctl)
  );

  poll_status_dpath #(.DataW(DataW), .PollBit(PollBit), .ToggleBit(ToggleBit)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lastData(lastData),
    .arrayData(arrayData), .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/poll_status_chk.sv
module poll_status_chk #(
  parameter int DataW     = 8,
  parameter int PollBit   = 7,
  parameter int ToggleBit = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             ceN,
  input logic             oeN,
  input logic             weN,
  input logic             busy,
  input logic [DataW-1:0] lastData,
  input logic [DataW-1:0] arrayData,
  input logic [DataW-1:0] busOut,
  input logic             busOe
);
  logic act;
  assign act = ~ceN & ~oeN & weN;

  p_oe_on_r1: assert property (@(posedge clk) disable iff (!rstN)
    act |=> busOe);
  p_oe_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !act |=> (!busOe && busOut == '0));
  p_poll_inv_r2: assert property (@(posedge clk) disable iff (!rstN)
    (act && busy) |=> busOut[PollBit] == ~$past(lastData[PollBit]));
  p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (act && busy && $past(act) && $past(rstN)) |=> $stable(busOut[ToggleBit]));
  p_true_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (act && !busy) |=> busOut == $past(arrayData));
  p_low_bits_r7: assert property (@(posedge clk) disable iff (!rstN)
    (act && busy) |=> busOut[ToggleBit-1:0] == $past(lastData[ToggleBit-1:0]));
endmodule

bind poll_status_top poll_status_chk #(
  .DataW(DataW), .PollBit(PollBit), .ToggleBit(ToggleBit)
) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .busy(busy),
  .lastData(lastData), .arrayData(arrayData), .busOut(busOut), .busOe(busOe)
);

// File: tb/poll_status_top_bench.sv
module poll_status_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1, oeN = 1'b1, weN = 1'b1, busy = 1'b0;
  logic [7:0] lastData = 8'h00, arrayData = 8'h00;
  logic [7:0] busOut;
  logic       busOe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [8:0] qExp[$];
  string      qTag[$];

  logic mTog = 1'b0;
  logic mPrev = 1'b0;

  always #4 clk = ~clk;

  poll_status_top u_poll_status_top (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .busy(busy),
    .lastData(lastData), .arrayData(arrayData), .busOut(busOut), .busOe(busOe)
  );

  task automatic drive(input logic c, input logic o, input logic w, input logic b,
                       input logic [7:0] ld, input logic [7:0] ad, input string tag);
    logic act;
    logic [7:0] d;
    @(negedge clk);
    ceN = c; oeN = o; weN = w; busy = b; lastData = ld; arrayData = ad;
    act = ~c & ~o & w;
    if (b && act && !mPrev) mTog = ~mTog;
    mPrev = act;
    if (!act) d = 8'h00;
    else if (b) d = {~ld[7], mTog, ld[5:0]};
    else d = ad;
    qExp.push_back({act, d});
    qTag.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qExp.size() > 0) begin
        logic [8:0] e;
        string t;
        e = qExp.pop_front();
        t = qTag.pop_front();
        total++;
        if ({busOe, busOut} !== e) begin
          bad++;
          $display("FAIL %s: got oe=%b data=%h expected oe=%b data=%h", t, busOe, busOut, e[8], e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;  // R1 reset state
    if (busOe !== 1'b0 || busOut !== 8'h00) begin
      bad++;
      $display("FAIL R1 reset: got oe=%b data=%h expected oe=0 data=00", busOe, busOut);
    end
    @(negedge clk); rstN = 1'b1;
    drive(1,1,1,0,8'h00,8'h3C,"R1 idle");
    drive(0,0,1,0,8'h00,8'h3C,"R6 array read");
    drive(0,0,1,0,8'h00,8'hC3,"R6 array read changes");
    drive(0,0,0,0,8'h00,8'hC3,"R1 write enable low");
    drive(1,0,1,0,8'h00,8'hC3,"R1 chip disabled");
    // busy: first access after reset gives bit6=1 (R3)
    drive(0,0,1,1,8'hA5,8'h11,"R3 first busy access");
    drive(0,0,1,1,8'hA5,8'h11,"R5 held read");
    drive(0,0,1,1,8'hA5,8'h11,"R5 held read");
    drive(0,1,1,1,8'hA5,8'h11,"R1 oe high");
    drive(0,0,1,1,8'hA5,8'h11,"R4 new access via oe");
    drive(1,0,1,1,8'hA5,8'h11,"R1 ce high");
    drive(0,0,1,1,8'hA5,8'h11,"R4 new access via ce");
    drive(1,1,1,1,8'h5A,8'h11,"R1 both high");
    drive(0,0,1,1,8'h5A,8'h11,"R2 R7 other byte");
    drive(0,1,1,1,8'h5A,8'h11,"R1 oe high");
    drive(0,0,1,1,8'h7F,8'h11,"R2 R7 bit7 zero");
    drive(0,0,1,1,8'h80,8'h11,"R5 held with new last byte");
    // write ends while read held: true data
    drive(0,0,1,0,8'h80,8'h96,"R6 done while held");
    drive(0,1,1,0,8'h80,8'h96,"R1 oe high");
    drive(0,0,1,0,8'h80,8'h69,"R6 read idle no advance");
    drive(0,1,1,0,8'h80,8'h69,"R1 oe high");
    drive(0,0,1,0,8'h80,8'h5F,"R6 read idle no advance");
    // busy starts while read held: polling mid cycle, no new access
    drive(0,0,1,1,8'h33,8'h5F,"R8 busy rises during read");
    drive(0,1,1,1,8'h33,8'h5F,"R1 oe high");
    drive(0,0,1,1,8'h33,8'h5F,"R8 toggle continues");
    drive(1,1,1,1,8'h33,8'h5F,"R1 both high");
    drive(0,0,1,1,8'h33,8'h5F,"R3 R4 access via both");
    drive(1,1,1,0,8'h33,8'h5F,"R1 idle");
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule